// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block is a time-division multiplexed switch for several serial streams. All streams share one bit clock and one frame pulse. Every frame, the byte in each input channel is collected and stored in a data memory. Each output stream and channel then sends one byte. A connection table entry for that output channel chooses the byte. It is either a byte received on some input stream and channel in the previous frame, or a constant byte held in the entry itself. The data memory has two banks that alternate by frame. Because of this, the output always reads a frame that has fully arrived, and the delay through the switch is exactly one frame.

The channel count per frame is set by a base count and a double-rate option, so one build serves either line rate. A synchronous host port has three uses: it writes the connection table, reads the table back, and reads the data memory to monitor received traffic. Host writes go into a pending copy of the table. The whole pending copy becomes active at the next frame boundary, so a frame is never switched with a half-updated table.

After reset the block samples the idle level of the frame pulse line to learn its polarity. It aligns to the first pulse it recognises, and only then starts driving switched data.

Top module: `tsi_switch`

## Requirements
- R1: During reset, and until the frame that opens with the second recognised frame pulse, every serial output is held at 1. That frame is the first switched frame.
- R2: Frame pulse polarity is learned from the first three clock cycles after reset is released. The majority level in those cycles is taken as the idle level, so both an active-high and an active-low one-cycle pulse are accepted.
- R3: A table entry with bit 8 clear is a connection. Its bits 6:5 name the source stream and bits 4:0 the source channel. The output channel carries the byte received at that source one frame earlier.
- R4: A table entry with bit 8 set is a message. The output channel carries entry bits 7:0 in every frame.
- R5: Serial data is sent MSB first. The input sampled at frame bit position 8c+k holds bit 7-k of channel c. The output bit for position p is stable during the clock cycle before the edge that samples input position p.
- R6: A host table write made during a frame does not change that frame's output. It takes effect from the next frame.
- R7: A host read with the data-memory select low returns the pending table entry at address {stream, channel} on the clock after the request. After reset every entry reads 9'h1FF (message mode, byte FF).
- R8: A host read with the data-memory select high returns, one clock later and zero-extended, the byte received at {stream, channel} in the last completed frame.
- R9: Output channel 0 switched from the last channel of any input stream carries that last channel's byte from the frame that has just ended.
- R10: A host write with the data-memory select high has no effect on the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock shared by all streams and the host port |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_i | input | 1 | Frame pulse, one cycle wide, polarity learned after reset |
| ser_in | input | NSTR (4) | Serial input streams |
| ser_out | output | NSTR (4) | Serial output streams |
| hst_en | input | 1 | Host request strobe |
| hst_we | input | 1 | Host write when high, read when low |
| hst_dmem | input | 1 | Host target: 1 data memory, 0 connection table |
| hst_addr | input | AW (7) | Host address {stream, channel} |
| hst_wdata | input | CM_W (9) | Host write data (table entry) |
| hst_rdata | output | CM_W (9) | Host read data, valid the clock after a read |

## Verification
The assertions take for granted a frame pulse that is one cycle wide and, once aligned, repeats exactly every frame length. They also assume at least three idle cycles of that line after reset, so the learned polarity is right. The table-hold check relies on host writes reaching only the pending copy, never the active one. The stimulus sends back-to-back frames of fixed length and leaves the frame line idle around each reset. It issues host requests only well inside a frame, away from the boundary, so each write lands in a known frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

   localparam int unsigned BYTE_W = 8;

   // table entry route selector, kept in the top bit of an entry
   typedef enum logic {
      ROUTE_LINK = 1'b0,
      ROUTE_MSG  = 1'b1
   } route_e;

   function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tsi_framer.sv
module tsi_framer #(
   parameter  int unsigned FRAME_BITS = 256,
   localparam int unsigned PW         = $clog2(FRAME_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frm_i,
   output logic [PW-1:0] pos_o,
   output logic          byte_end_o,
   output logic          frame_edge_o,
   output logic          bank_o,
   output logic          live_o
);

   localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

   if (FRAME_BITS < 16 || (FRAME_BITS & (FRAME_BITS - 1)) != 0) begin : g_bad_frame
      $error("tsi_framer: FRAME_BITS must be a power of two of at least 16");
   end

   logic [1:0]    det_cnt;
   logic [1:0]    det_ones;
   logic          det_done;
   logic          pol_high;
   logic          aligned;
   logic          bank_q;
   logic          live_q;
   logic [PW-1:0] pos_q;
   logic [PW-1:0] pos_d;
   logic          fp;

   assign fp = det_done & (frm_i == pol_high);

   always_comb begin
      if (fp)                pos_d = '0;
      else if (pos_q == LAST) pos_d = '0;
      else                   pos_d = pos_q + 1'b1;
   end

   // idle level = majority of the first three samples after reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         det_cnt  <= '0;
         det_ones <= '0;
         det_done <= 1'b0;
         pol_high <= 1'b1;
      end else if (!det_done) begin
         det_cnt  <= det_cnt + 2'd1;
         det_ones <= det_ones + {1'b0, frm_i};
         if (det_cnt == 2'd2) begin
            det_done <= 1'b1;
            pol_high <= ((det_ones + {1'b0, frm_i}) < 2'd2);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         aligned <= 1'b0;
         bank_q  <= 1'b0;
         live_q  <= 1'b0;
      end else begin
         pos_q   <= pos_d;
         aligned <= aligned | fp;
         if (pos_d == '0) bank_q <= ~bank_q;
         if (frame_edge_o) live_q <= 1'b1;
      end
   end

   assign pos_o        = pos_d;
   assign byte_end_o   = (pos_d[2:0] == 3'b111);
   assign frame_edge_o = aligned & (pos_d == LAST);
   assign bank_o       = bank_q;
   assign live_o       = live_q;

   // R2
   pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      det_done |=> $stable(pol_high));

   // R5
   frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fp && aligned) |-> (pos_q == LAST));

   // R1
   live_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(live_q) |-> $past(frame_edge_o));

endmodule

// File: rtl/tsi_rx_lane.sv
module tsi_rx_lane import tsi_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sin,
   output logic [BYTE_W-1:0] word_o
);

   logic [BYTE_W-2:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[BYTE_W-3:0], sin};
   end

   // byte completed by the bit sampled at this edge
   assign word_o = {sh_q, sin};

endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane import tsi_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_byte,
   input  logic              live,
   output logic              sout
);

   logic [BYTE_W-1:0] osh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    osh_q <= '1;
      else if (load) osh_q <= load_byte;
      else           osh_q <= {osh_q[BYTE_W-2:0], 1'b1};
   end

   assign sout = live ? osh_q[BYTE_W-1] : 1'b1;

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch import tsi_pkg::*; #(
   parameter  int unsigned NSTR        = 4,
   parameter  int unsigned BASE_CH     = 16,
   parameter  bit          DOUBLE_RATE = 1'b1,
   localparam int unsigned NCH         = DOUBLE_RATE ? 2 * BASE_CH : BASE_CH,
   localparam int unsigned SW          = $clog2(NSTR),
   localparam int unsigned CW          = $clog2(NCH),
   localparam int unsigned AW          = SW + CW,
   localparam int unsigned PAY_W       = wmax(BYTE_W, AW),
   localparam int unsigned CM_W        = PAY_W + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frm_i,
   input  logic [NSTR-1:0] ser_in,
   output logic [NSTR-1:0] ser_out,
   input  logic            hst_en,
   input  logic            hst_we,
   input  logic            hst_dmem,
   input  logic [AW-1:0]   hst_addr,
   input  logic [CM_W-1:0] hst_wdata,
   output logic [CM_W-1:0] hst_rdata
);

   localparam int unsigned FRAME_BITS = NCH * BYTE_W;
   localparam int unsigned PW         = $clog2(FRAME_BITS);
   localparam int unsigned NENT       = NSTR * NCH;
   localparam int unsigned NDM        = 2 * NENT;

   if (NSTR < 2 || (NSTR & (NSTR - 1)) != 0) begin : g_bad_nstr
      $error("tsi_switch: NSTR must be a power of two of at least 2");
   end
   if (BASE_CH < 2 || (BASE_CH & (BASE_CH - 1)) != 0) begin : g_bad_ch
      $error("tsi_switch: BASE_CH must be a power of two of at least 2");
   end

   logic [PW-1:0] cur_pos;
   logic          byte_end;
   logic          frame_edge;
   logic          bank;
   logic          live;

   tsi_framer #(.FRAME_BITS(FRAME_BITS)) u_framer (
      .clk          (clk),
      .rst_n        (rst_n),
      .frm_i        (frm_i),
      .pos_o        (cur_pos),
      .byte_end_o   (byte_end),
      .frame_edge_o (frame_edge),
      .bank_o       (bank),
      .live_o       (live)
   );

   logic [CM_W-1:0]            pend [NENT];
   logic [NENT-1:0][CM_W-1:0]  act;
   logic [BYTE_W-1:0]          dmem [NDM];
   logic [BYTE_W-1:0]          rx_word [NSTR];
   logic [BYTE_W-1:0]          tx_byte [NSTR];
   logic [CM_W-1:0]            ent [NSTR];
   logic [CW-1:0]              ch_cur;
   logic [CW-1:0]              ch_nxt;

   assign ch_cur = cur_pos[PW-1:3];
   assign ch_nxt = ch_cur + 1'b1;

   for (genvar s = 0; s < NSTR; s++) begin : g_lane
      tsi_rx_lane u_rx (
         .clk    (clk),
         .rst_n  (rst_n),
         .sin    (ser_in[s]),
         .word_o (rx_word[s])
      );
      tsi_tx_lane u_tx (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (byte_end),
         .load_byte (tx_byte[s]),
         .live      (live),
         .sout      (ser_out[s])
      );
   end

   // next-channel fetch: at a frame edge the new table and the just-closed bank apply
   always_comb begin
      for (int s = 0; s < NSTR; s++) begin
         ent[s] = frame_edge ? pend[{SW'(s), ch_nxt}] : act[{SW'(s), ch_nxt}];
         if (route_e'(ent[s][CM_W-1]) == ROUTE_MSG) begin
            tx_byte[s] = ent[s][BYTE_W-1:0];
         end else if (frame_edge && ent[s][CW-1:0] == CW'(NCH - 1)) begin
            tx_byte[s] = rx_word[ent[s][AW-1:CW]];
         end else begin
            tx_byte[s] = dmem[{frame_edge ? bank : ~bank, ent[s][AW-1:0]}];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (byte_end) begin
         for (int s = 0; s < NSTR; s++) begin
            dmem[{bank, SW'(s), ch_cur}] <= rx_word[s];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NENT; i++) pend[i] <= '1;
      end else if (hst_en && hst_we && !hst_dmem) begin
         pend[hst_addr] <= hst_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act <= '1;
      end else if (frame_edge) begin
         for (int i = 0; i < NENT; i++) act[i] <= pend[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hst_rdata <= '0;
      end else if (hst_en && !hst_we) begin
         if (hst_dmem) hst_rdata <= {{(CM_W-BYTE_W){1'b0}}, dmem[{~bank, hst_addr}]};
         else          hst_rdata <= pend[hst_addr];
      end
   end

   // R6
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_edge |=> $stable(act));

endmodule

// File: tb/tsi_switch_test.sv
module tsi_switch_test;

   localparam int CLK_PERIOD = 10;
   localparam int NSTR = 4;
   localparam int NCH  = 32;
   localparam int FB   = NCH * 8;
   localparam int AW   = 7;
   localparam int CM_W = 9;
   localparam int NENT = NSTR * NCH;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            frm = 1'b0;
   logic [NSTR-1:0] sin = '0;
   logic [NSTR-1:0] sout;
   logic            h_en = 1'b0;
   logic            h_we = 1'b0;
   logic            h_dm = 1'b0;
   logic [AW-1:0]   h_addr = '0;
   logic [CM_W-1:0] h_wdata = '0;
   logic [CM_W-1:0] h_rdata;

   int n_cmp = 0;
   int n_bad = 0;
   bit run = 1'b0;
   bit pol_high_b = 1'b1;
   int p = 0;
   int n = 1;
   logic [CM_W-1:0] pend_m [NENT];
   logic [CM_W-1:0] act_m  [NENT];
   logic [7:0]      obyte  [NSTR];
   logic            obits  [NSTR][FB];

   always #(CLK_PERIOD/2) clk = ~clk;

   tsi_switch uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .frm_i     (frm),
      .ser_in    (sin),
      .ser_out   (sout),
      .hst_en    (h_en),
      .hst_we    (h_we),
      .hst_dmem  (h_dm),
      .hst_addr  (h_addr),
      .hst_wdata (h_wdata),
      .hst_rdata (h_rdata)
   );

   function automatic logic [7:0] pat(input int fr, input int s, input int c);
      return 8'(fr * 37 + s * 64 + c * 5 + 3);
   endfunction

   function automatic logic [CM_W-1:0] lnk(input int ss, input int sc);
      return {2'b00, 2'(ss), 5'(sc)};
   endfunction

   function automatic logic [CM_W-1:0] msg(input logic [7:0] b);
      return {1'b1, b};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
      end
   endtask

   task automatic check_slot(input int fr, input int s, input int c, input logic [7:0] got);
      logic [CM_W-1:0] e;
      logic [7:0] exp;
      string tag;
      e = act_m[s*NCH + c];
      if (fr < 2) begin
         exp = 8'hFF; tag = "R1";
      end else if (e[8]) begin
         exp = e[7:0]; tag = "R4";
      end else begin
         exp = pat(fr - 1, int'(e[6:5]), int'(e[4:0]));
         tag = (c == 0 && e[4:0] == 5'd31) ? "R9" : "R3";
      end
      if (fr >= 2 && pend_m[s*NCH + c] != e) tag = "R6";
      else if (fr >= 2 && !pol_high_b) tag = "R2";
      check(got == exp, tag, 16'(got), 16'(exp));
   endtask

   // frame driver: samples output bit p, then drives input bit p
   initial begin
      forever begin
         @(negedge clk);
         if (run) begin
            if (p == 0) for (int i = 0; i < NENT; i++) act_m[i] = pend_m[i];
            for (int s = 0; s < NSTR; s++) begin
               obyte[s] = {obyte[s][6:0], sout[s]};
               obits[s][p] = sout[s];
            end
            if (p % 8 == 7) for (int s = 0; s < NSTR; s++) check_slot(n, s, p / 8, obyte[s]);
            for (int s = 0; s < NSTR; s++) begin
               logic [7:0] b;
               b = pat(n, s, p / 8);
               sin[s] = b[7 - (p % 8)];
            end
            frm = (p == 0) ? pol_high_b : ~pol_high_b;
            p++;
            if (p == FB) begin
               p = 0;
               n++;
            end
         end else begin
            sin = '0;
            frm = ~pol_high_b;
         end
      end
   end

   task automatic wait_window(input int lo, input int hi);
      if (!run) begin
         @(negedge clk);
         return;
      end
      do @(negedge clk); while (!(p >= lo && p <= hi));
   endtask

   task automatic host_write(input int addr, input logic [CM_W-1:0] d, input bit dm);
      h_en = 1'b1; h_we = 1'b1; h_dm = dm; h_addr = AW'(addr); h_wdata = d;
      @(negedge clk);
      h_en = 1'b0; h_we = 1'b0; h_dm = 1'b0;
      if (!dm) pend_m[addr] = d;
   endtask

   task automatic host_read(input int addr, input bit dm, output logic [CM_W-1:0] d);
      h_en = 1'b1; h_we = 1'b0; h_dm = dm; h_addr = AW'(addr);
      @(negedge clk);
      d = h_rdata;
      h_en = 1'b0; h_dm = 1'b0;
   endtask

   task automatic wait_frames(input int k);
      repeat (k * FB) @(negedge clk);
   endtask

   task automatic do_reset(input bit pol);
      run = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      pol_high_b = pol;
      for (int i = 0; i < NENT; i++) begin
         pend_m[i] = '1;
         act_m[i]  = '1;
      end
      repeat (3) @(negedge clk);
      check(sout == '1, "R1", 16'(sout), 16'hF);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      p = 0; n = 1; run = 1'b1;
   endtask

   task automatic t_reset_state;
      logic [CM_W-1:0] d;
      do_reset(1'b1);
      run = 1'b0;
      host_read(5, 1'b0, d);
      check(d == 9'h1FF, "R7", 16'(d), 16'h1FF);
      run = 1'b1;
      wait_frames(3);
   endtask

   task automatic t_connect;
      for (int s = 0; s < NSTR; s++)
         for (int c = 0; c < NCH; c++) begin
            wait_window(4, FB - 8);
            host_write(s * NCH + c, lnk(s ^ 1, (c * 3 + 1) % NCH), 1'b0);
         end
      wait_frames(3);
   endtask

   task automatic t_boundary;
      // R9: channel 0 fed from last channel of previous frame
      wait_window(4, FB - 8);
      host_write(2 * NCH + 0, lnk(1, NCH - 1), 1'b0);
      wait_window(4, FB - 8);
      host_write(0 * NCH + 0, lnk(3, NCH - 1), 1'b0);
      wait_frames(3);
   endtask

   task automatic t_message;
      logic [7:0] b;
      wait_window(16, 40);
      host_write(3 * NCH + 5, msg(8'h80), 1'b0);
      host_write(0 * NCH + 31, msg(8'h5A), 1'b0);
      host_write(1 * NCH + 10, msg(8'h00), 1'b0);
      wait_frames(3);
      wait_window(100, 120);
      check(obits[3][40] == 1'b1, "R5", 16'(obits[3][40]), 16'h1);
      check(obits[3][41] == 1'b0, "R5", 16'(obits[3][41]), 16'h0);
      for (int k = 0; k < 8; k++) b[7 - k] = obits[3][40 + k];
      check(b == 8'h80, "R5", 16'(b), 16'h80);
   endtask

   task automatic t_host_read;
      logic [CM_W-1:0] d;
      logic [7:0] exp;
      int fr;
      wait_window(20, 60);
      host_read(3 * NCH + 5, 1'b0, d);
      check(d == msg(8'h80), "R7", 16'(d), 16'(msg(8'h80)));
      fr = n;
      exp = pat(fr - 1, 2, 7);
      host_read(2 * NCH + 7, 1'b1, d);
      check(d == {1'b0, exp}, "R8", 16'(d), 16'(exp));
      host_write(2 * NCH + 7, {1'b0, ~exp}, 1'b1);
      host_read(2 * NCH + 7, 1'b1, d);
      check(d == {1'b0, exp}, "R10", 16'(d), 16'(exp));
      check(n == fr, "R8", 16'(n), 16'(fr));
      wait_frames(1);
   endtask

   task automatic t_polarity;
      do_reset(1'b0);
      for (int c = 0; c < 8; c++) begin
         wait_window(4, FB - 8);
         host_write(0 * NCH + c, lnk(2, c), 1'b0);
      end
      wait_window(4, FB - 8);
      host_write(1 * NCH + 0, lnk(0, NCH - 1), 1'b0);
      wait_window(4, FB - 8);
      host_write(3 * NCH + 9, lnk(1, 4), 1'b0);
      wait_frames(4);
   endtask

   initial begin
      t_reset_state();
      t_connect();
      t_boundary();
      t_message();
      t_host_read();
      t_polarity();
      run = 1'b0;
      @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule